// File: doc/BRIEF.md
# Stereo Serial Audio Output Shifter

This block turns pairs of 24-bit two's complement audio samples into a single serial data line. The line is timed by a bit clock and a channel-select clock that arrive from outside. Both clocks are sampled in the block's own system clock domain. The block detects bit-clock falling edges and channel-clock transitions there, and it updates the data line one system clock after each falling edge. A receiver then samples that line on the following bit-clock rising edge.

Two framings are supported. In the first, the most significant bit starts at the channel-clock transition. In the second, the whole stream is delayed by one bit slot. The framing is chosen once, from a strap input captured on the first clock after reset is released. The same logic serves 48 and 64 bit clocks per frame: unused slots carry zero, and a channel-clock edge that arrives early restarts the shift.

Samples enter through a valid/ready handshake into a one-pair holding slot. At the start of every left half-frame, a waiting pair moves into use. If no pair is waiting, the pair already in use is sent again.

Top module: `stereo_serial_shifter`

## Requirements
- R1: While reset is held and on the first clock after its release, `sdata_o` is 0 and `smp_ready_o` is 1.
- R2: `fmt_strap_i` is captured on the first clock after reset deasserts: 1 selects the delayed framing, 0 the edge-aligned framing. The choice then holds until the next reset, whatever the strap does afterwards.
- R3: Edge-aligned framing. A half-frame starts at the bit-clock falling edge where `lrck_i` differs from its level at the previous falling edge. The word is sent MSB first, with the MSB in the slot that begins at that edge. `lrck_i` high carries the left word and low carries the right word.
- R4: Delayed framing. The line carries the edge-aligned bit stream one slot late, with `lrck_i` low carrying the left word. At 48 slots per frame, a word's LSB therefore appears in the first slot of the next half-frame.
- R5: In the underlying edge-aligned stream, every slot after the 24th of a half-frame is 0. After reset, the line stays 0 until the first half-frame start, and the `lrck_i` reference is taken as low at that point.
- R6: A channel-clock transition that arrives before 24 slots have been sent abandons the current word and starts the next word from its MSB.
- R7: `sdata_o` changes only on the system clock edge at which a bit-clock falling edge is detected. That edge is the first one that samples `sclk_i` low after a high sample.
- R8: The holding slot takes one pair. `smp_ready_o` is 1 exactly when the slot is empty, and a pair is accepted on a clock where `smp_valid_i` and `smp_ready_o` are both 1.
- R9: At each left half-frame start, a waiting pair is moved into use. With no pair waiting, the previous pair is repeated; all zeros is sent before any pair has been loaded.
- R10: A pair accepted on the same clock as a left half-frame start is not used in that frame. It waits and is sent in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_strap_i | input | 1 | Framing strap, 1 = delayed framing, 0 = edge-aligned |
| sclk_i | input | 1 | Bit clock, synchronous to `clk` |
| lrck_i | input | 1 | Channel-select clock, changes with the bit clock falling edge |
| smp_valid_i | input | 1 | A sample pair is offered |
| smp_ready_o | output | 1 | Holding slot is empty |
| smp_left_i | input | 24 | Left sample, two's complement |
| smp_right_i | input | 24 | Right sample, two's complement |
| sdata_o | output | 1 | Serial data line |

## Verification
The acceptance of a new pair and the loading of the held pair at a left half-frame start can land on the same clock. The bench provokes this by raising `smp_valid_i` on the very clock whose bit-clock falling edge carries the left channel-clock transition, with the holding slot empty. The reference model applies the load before the acceptance. It expects the frame to repeat the earlier pair and the next frame to carry the new one, and it checks the serial line every clock as well as the deserialised words.

// File: rtl/ser_types_pkg.sv
// Shared width and types for the stereo serial shifter.
// Assumes one fixed sample width for both channels.
package ser_types_pkg;

    parameter int unsigned SMP_W = 24;
    localparam int unsigned SLOT_W = $clog2(SMP_W + 1);

    typedef enum logic {
        FMT_EDGE  = 1'b0,
        FMT_DELAY = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        logic [SMP_W-1:0] lft;
        logic [SMP_W-1:0] rgt;
    } smp_pair_t;

endpackage

// File: rtl/ser_clk_edges.sv
// Detects bit-clock falling edges and half-frame starts.
// Assumes sclk_i and lrck_i are already synchronous to clk and that each
// level of sclk_i lasts at least one clk cycle. The lrck reference is low
// after reset.
module ser_clk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic lrck_i,
    output logic fall_o,
    output logic half_o
);
    logic sclk_q;
    logic lrck_ref;

    assign fall_o = sclk_q & ~sclk_i;
    assign half_o = fall_o & (lrck_i ^ lrck_ref);

    // Keep the last bit-clock sample and the lrck level seen at the last fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            lrck_ref <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            if (fall_o) begin
                lrck_ref <= lrck_i;
            end
        end
    end

    // R3: a half-frame start is always followed by a reference equal to lrck
    a_r3_ref_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        half_o |=> (lrck_ref == $past(lrck_i)));

endmodule

// File: rtl/ser_pair_hold.sv
// One-entry holding slot for sample pairs, plus the pair currently in use.
// A waiting pair moves into use on a load request. A pair accepted on that
// same clock stays waiting for the next load.
module ser_pair_hold
    import ser_types_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid_i,
    input  smp_pair_t pair_in_i,
    output logic      ready_o,
    input  logic      load_i,
    output smp_pair_t pair_use_o
);
    smp_pair_t pend_q;
    smp_pair_t act_q;
    logic      pend_full;

    assign ready_o    = ~pend_full;
    assign pair_use_o = (load_i && pend_full) ? pend_q : act_q;

    // Move a waiting pair into use, or accept a new pair into an empty slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            act_q     <= '0;
            pend_full <= 1'b0;
        end else if (load_i && pend_full) begin
            act_q     <= pend_q;
            pend_full <= 1'b0;
        end else if (valid_i && !pend_full) begin
            pend_q    <= pair_in_i;
            pend_full <= 1'b1;
        end
    end

    // R8: a full slot keeps its pair until a load takes it
    a_r8_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_full && !load_i) |=> (pend_full && $stable(pend_q)));

    // R9: a load consumes the waiting pair
    a_r9_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && pend_full) |=> (!pend_full && act_q == $past(pend_q)));

endmodule

// File: rtl/ser_bit_shift.sv
// Slot counter and serial bit selection for both framings.
// The edge-aligned bit comes straight from the word. The delayed framing
// sends the previous edge-aligned bit. Slots past the word width give 0.
module ser_bit_shift
    import ser_types_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fall_i,
    input  logic      half_i,
    input  logic      left_ch_i,
    input  logic      dly_fmt_i,
    input  smp_pair_t pair_i,
    output logic      sdata_o
);
    logic [SLOT_W-1:0] cnt_q;
    logic [SLOT_W-1:0] cnt_nx;
    logic [SMP_W-1:0]  word;
    logic [SMP_W-1:0]  word_sh;
    logic              edge_bit;
    logic              dly_bit;

    // Next slot index: restart on a half start, saturate past the word.
    always_comb begin
        if (half_i) begin
            cnt_nx = '0;
        end else if (cnt_q == SLOT_W'(SMP_W)) begin
            cnt_nx = cnt_q;
        end else begin
            cnt_nx = cnt_q + 1'b1;
        end
    end

    // Pick the channel word and the bit for this slot (0 once shifted out).
    always_comb begin
        word     = left_ch_i ? pair_i.lft : pair_i.rgt;
        word_sh  = word << cnt_nx;
        edge_bit = word_sh[SMP_W-1];
    end

    // Advance the slot and drive the line once per bit-clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= SLOT_W'(SMP_W);
            dly_bit <= 1'b0;
            sdata_o <= 1'b0;
        end else if (fall_i) begin
            cnt_q   <= cnt_nx;
            dly_bit <= edge_bit;
            sdata_o <= dly_fmt_i ? dly_bit : edge_bit;
        end
    end

    // R7: the line only moves on a detected falling edge
    a_r7_hold_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(sdata_o));

    // R5: edge-aligned slots past the word width are zero
    a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && !half_i && !dly_fmt_i && cnt_q >= SLOT_W'(SMP_W - 1)) |=> !sdata_o);

endmodule

// File: rtl/stereo_serial_shifter.sv
// Top of the stereo serial shifter. It latches the framing strap once
// after reset and wires together edge detection, pair holding and the
// bit shifter. Assumes the bit clock is sampled at least twice per period.
module stereo_serial_shifter
    import ser_types_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fmt_strap_i,
    input  logic             sclk_i,
    input  logic             lrck_i,
    input  logic             smp_valid_i,
    output logic             smp_ready_o,
    input  logic [SMP_W-1:0] smp_left_i,
    input  logic [SMP_W-1:0] smp_right_i,
    output logic             sdata_o
);
    frame_fmt_e fmt_q;
    logic       fmt_done;
    logic       fall;
    logic       half;
    logic       left_ch;
    logic       dly_fmt;
    smp_pair_t  pair_in;
    smp_pair_t  pair_use;

    // Capture the strap on the first clock out of reset, then hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q    <= FMT_EDGE;
            fmt_done <= 1'b0;
        end else if (!fmt_done) begin
            fmt_q    <= frame_fmt_e'(fmt_strap_i);
            fmt_done <= 1'b1;
        end
    end

    assign dly_fmt = (fmt_q == FMT_DELAY);
    assign left_ch = lrck_i ^ dly_fmt;
    assign pair_in = '{lft: smp_left_i, rgt: smp_right_i};

    ser_clk_edges u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_i),
        .lrck_i (lrck_i),
        .fall_o (fall),
        .half_o (half)
    );

    ser_pair_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (smp_valid_i),
        .pair_in_i  (pair_in),
        .ready_o    (smp_ready_o),
        .load_i     (half & left_ch),
        .pair_use_o (pair_use)
    );

    ser_bit_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (fall),
        .half_i    (half),
        .left_ch_i (left_ch),
        .dly_fmt_i (dly_fmt),
        .pair_i    (pair_use),
        .sdata_o   (sdata_o)
    );

    // R2: once captured, the framing choice never changes before reset
    a_r2_fmt_held: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_done |=> (fmt_done && $stable(fmt_q)));

endmodule

// File: tb/stereo_serial_shifter_test.sv
module stereo_serial_shifter_test;
    localparam int W = 24;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         strap = 1'b0;
    logic         sclk = 1'b1;
    logic         lrck = 1'b0;
    logic         s_valid = 1'b0;
    logic [W-1:0] s_left = '0;
    logic [W-1:0] s_right = '0;
    logic         s_ready;
    logic         sdata;

    stereo_serial_shifter uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_strap_i (strap),
        .sclk_i      (sclk),
        .lrck_i      (lrck),
        .smp_valid_i (s_valid),
        .smp_ready_o (s_ready),
        .smp_left_i  (s_left),
        .smp_right_i (s_right),
        .sdata_o     (sdata)
    );

    int n_checks = 0;
    int n_fails  = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model (updated on every clock) ----------
    bit           m_started = 0;
    bit           m_dly_fmt = 0;
    bit           m_sclk_prev = 0;
    bit           m_lr_ref = 0;
    int           m_k = W;
    bit           m_dbit = 0;
    bit           m_exp_sd = 0;
    int           m_acc = 0;
    bit           m_fall, m_hs, m_left, m_ebit;
    logic [W-1:0] m_cur_l = '0, m_cur_r = '0, m_word;
    logic [W-1:0] q_l[$];
    logic [W-1:0] q_r[$];
    logic [W-1:0] exp_words[$];
    event         ev_left;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 0; m_sclk_prev = 0; m_lr_ref = 0; m_k = W;
            m_dbit = 0; m_exp_sd = 0; m_cur_l = '0; m_cur_r = '0;
            q_l.delete(); q_r.delete(); exp_words.delete();
        end else begin
            if (!m_started) begin
                m_dly_fmt = strap;
                m_started = 1;
            end
            m_fall = m_sclk_prev && !sclk;
            if (m_fall) begin
                m_hs     = (lrck != m_lr_ref);
                m_lr_ref = lrck;
                m_left   = lrck ^ m_dly_fmt;
                if (m_hs) begin
                    m_k = 0;
                    if (m_left && q_l.size() > 0) begin
                        m_cur_l = q_l.pop_front();
                        m_cur_r = q_r.pop_front();
                    end
                    exp_words.push_back(m_left ? m_cur_l : m_cur_r);
                end else if (m_k < W) begin
                    m_k++;
                end
                m_word   = m_left ? m_cur_l : m_cur_r;
                m_ebit   = (m_k < W) ? m_word[W-1-m_k] : 1'b0;
                m_exp_sd = m_dly_fmt ? m_dbit : m_ebit;
                m_dbit   = m_ebit;
            end
            m_sclk_prev = sclk;
            if (s_valid && s_ready) begin
                q_l.push_back(s_left);
                q_r.push_back(s_right);
                m_acc++;
            end
        end
    end

    // Per-clock comparison of the line (R7 timing) and the ready flag (R8).
    bit    chk_on = 0;
    string scen_tag = "R3";
    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            chk(sdata === m_exp_sd,
                $sformatf("%s R7 line", (m_k >= W && !m_dly_fmt) ? "R5" : scen_tag),
                W'(sdata), W'(m_exp_sd));
            chk(s_ready === (q_l.size() == 0), "R8 ready", W'(s_ready), W'(q_l.size() == 0));
        end
    end

    // ---------------- deserialiser ------------------------------------
    bit           tb_dly = 0;
    bit           des_en = 0;
    bit           des_on = 0;
    int           des_cnt = 0;
    logic [W-1:0] des_word = '0;

    task automatic des_sample(input int s);
        logic [W-1:0] e;
        if (des_en && !des_on && s == (tb_dly ? 1 : 0) && exp_words.size() > 0) begin
            des_on = 1; des_cnt = 0; des_word = '0;
        end
        if (des_on) begin
            des_word = {des_word[W-2:0], sdata};
            des_cnt++;
            if (des_cnt == W) begin
                e = exp_words.pop_front();
                chk(des_word === e, $sformatf("%s word", scen_tag), des_word, e);
                des_on = 0;
            end
        end
    endtask

    // ---------------- stimulus ----------------------------------------
    task automatic drive_half(input bit lr, input int ns);
        for (int s = 0; s < ns; s++) begin
            @(negedge clk);
            sclk = 1'b0;
            if (s == 0) begin
                lrck = lr;
                if (lr ^ tb_dly) -> ev_left;
            end
            @(negedge clk);
            @(negedge clk);
            des_sample(s);
            sclk = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic run_frames(input int nfr, input int per_half);
        for (int f = 0; f < nfr; f++) begin
            drive_half(~tb_dly, per_half);
            drive_half(tb_dly, per_half);
        end
    endtask

    task automatic offer(input logic [W-1:0] l, input logic [W-1:0] r);
        int c;
        c = m_acc;
        s_valid = 1'b1; s_left = l; s_right = r;
        while (m_acc == c) @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic feed(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            offer(24'h800000 ^ W'((base + i) * 24'h01A3C5), 24'h7FFFFF ^ W'((base + i) * 24'h0F0E1D));
        end
    endtask

    task automatic start_run(input bit strap_v, input string tag);
        chk_on = 0; des_en = 0; des_on = 0;
        rst_n = 1'b0; strap = strap_v; sclk = 1'b1; lrck = 1'b0; s_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tb_dly = strap_v; scen_tag = tag; chk_on = 1;
    endtask

    initial begin
        // R1: reset state
        start_run(1'b0, "R3");
        chk(sdata === 1'b0, "R1 line after reset", W'(sdata), '0);
        chk(s_ready === 1'b1, "R1 ready after reset", W'(s_ready), W'(1));

        // R3: edge-aligned framing, 64 and 48 slots per frame
        des_en = 1;
        fork run_frames(6, 32); feed(5, 1); join
        start_run(1'b0, "R3"); des_en = 1;
        fork run_frames(6, 24); feed(5, 11); join

        // R4: delayed framing, 64 and 48 slots per frame
        start_run(1'b1, "R4"); des_en = 1;
        fork run_frames(6, 32); feed(5, 21); join
        start_run(1'b1, "R4"); des_en = 1;
        fork run_frames(6, 24); feed(5, 31); join

        // R9: one pair, then frames with none pending repeat it
        start_run(1'b0, "R9"); des_en = 1;
        fork run_frames(5, 32); feed(1, 41); join

        // R6: early channel-clock edges restart from the MSB
        start_run(1'b1, "R6");
        fork
            for (int i = 0; i < 3; i++) begin drive_half(1'b1, 20); drive_half(1'b0, 13); end
            feed(3, 51);
        join
        start_run(1'b0, "R6");
        fork
            for (int i = 0; i < 3; i++) begin drive_half(1'b1, 17); drive_half(1'b0, 9); end
            feed(3, 55);
        join

        // R2: strap changes after capture must have no effect
        start_run(1'b1, "R2"); des_en = 1;
        strap = 1'b0;
        fork run_frames(3, 32); feed(2, 61); join

        // R10: accept on the same clock as a left half-frame start
        start_run(1'b0, "R10"); des_en = 1;
        fork
            run_frames(4, 32);
            begin
                offer(24'h123456, 24'hFEDCBA);
                @(ev_left);
                @(ev_left);
                offer(24'hA5A5A5, 24'h5A5A5A);
            end
        join

        chk_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule